// File: doc/BRIEF.md
# Pin Edge Interrupt and Event Router

This block watches the pins of several 16-bit ports and turns edges on them into interrupt requests and event pulses. It has sixteen lines, numbered 0 to 15. Line n listens to pin n of exactly one port, and a small selector field for each line chooses that port. Pins are asynchronous to the block clock. They pass through a two-stage synchronizer, and an edge is found by comparing each line's synchronized level with the level it held one cycle earlier.

Each line has four independent enables: rising trigger, falling trigger, interrupt path and event path. A qualifying edge on a line with its event path enabled produces a one-cycle pulse on that line's event output. A qualifying edge on a line with its interrupt path enabled sets that line's sticky pending flag. The interrupt request output shows the pending flag gated by the interrupt enable. Software clears a pending flag by writing a one to it.

All configuration goes through a simple single-cycle write bus with a combinational read port.

Top module: `edge_irq_router`

## Requirements
- R1: After reset, every configuration field and every pending flag is zero, every register reads back as zero, and `irq_o` and `evt_o` are all zero.
- R2: The selector for line n sits at register address n>>2, in bits [4*(n%4)+3 : 4*(n%4)]. The field value is the index of the source port. A value at or above NUM_PORTS connects the line to a constant 0. Pins of ports that are not selected have no effect on the line.
- R3: Bit n of address 4 enables rising (0-to-1) triggers on line n, and bit n of address 5 enables falling (1-to-0) triggers. With both bits set, either edge triggers the line. With neither set, the line never triggers. Edges are judged on the synchronized pin: a pin change made before clock edge k takes effect at the outputs after clock edge k+2.
- R4: Bit n of address 7 enables the event path. A trigger on an enabled line makes `evt_o[n]` high for exactly one cycle. The event path never sets a pending flag.
- R5: Bit n of address 6 enables the interrupt path. A trigger on line n sets pending bit n only while that enable is set.
- R6: `irq_o[n]` is high exactly when pending bit n and interrupt enable bit n are both set. Clearing the enable hides the request, but the pending bit stays set and still reads back at address 8.
- R7: Writing address 8 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged. If a trigger and a clearing write reach the same line in the same cycle, the pending bit stays set.
- R8: Changing a line's selector never produces a trigger by itself, even when the old and new source levels differ.
- R9: Addresses 0 to 3 read back 16 selector bits, addresses 4 to 7 read back 16 enable bits, and address 8 reads back the pending bits. Every other address, and every bit above bit 15, reads as zero. Configuration changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PORTS*16 | Port pins, asynchronous; bit p*16+n is pin n of port p |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | 16 | Interrupt request per line |
| evt_o | output | 16 | One-cycle event pulse per line |

## Verification
The assertions take for granted that a write strobe lasts one cycle and that a selector changes only through such a write. They also assume that a pin level, once changed, holds for several cycles, so that each edge is seen once and the single-cycle event check is meaningful. The bench changes pins and bus inputs only at falling clock edges and holds every pin level for at least three cycles. It also reconfigures a line only while that line's triggers are disabled or its source is stable. The one exception is the selector-change case, which deliberately switches between sources at different levels with both triggers enabled.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int LINES          = 16;
    localparam int SEL_W          = 4;
    localparam int FIELDS_PER_REG = 4;
    localparam int ROUTE_REGS     = LINES / FIELDS_PER_REG;
    localparam int ROUTE_BITS     = FIELDS_PER_REG * SEL_W;

    typedef enum logic [3:0] {
        ADDR_ROUTE0  = 4'd0,
        ADDR_ROUTE1  = 4'd1,
        ADDR_ROUTE2  = 4'd2,
        ADDR_ROUTE3  = 4'd3,
        ADDR_RISE_EN = 4'd4,
        ADDR_FALL_EN = 4'd5,
        ADDR_IRQ_EN  = 4'd6,
        ADDR_EVT_EN  = 4'd7,
        ADDR_PENDING = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             rise_en;
        logic             fall_en;
        logic             irq_en;
        logic             evt_en;
    } line_cfg_t;

    // Trigger decision for one line: gated by a stable source selection.
    function automatic logic edge_hit(input logic prev, input logic cur,
                                      input logic stable, input line_cfg_t c);
        logic up;
        logic down;
        up   = stable & cur & ~prev;
        down = stable & ~cur & prev;
        return (up & c.rise_en) | (down & c.fall_en);
    endfunction

endpackage

// File: rtl/eirq_pin_sync.sv
module eirq_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import edge_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [LINES-1:0]      pend_i,
    output line_cfg_t [LINES-1:0] cfg_o,
    output logic [LINES-1:0]      clr_o,
    output logic [DATA_W-1:0]     rdata_o
);
    localparam int ROUTE_TOTAL = ROUTE_REGS * ROUTE_BITS;

    logic [ROUTE_TOTAL-1:0] route_q;
    logic [LINES-1:0]       rise_q;
    logic [LINES-1:0]       fall_q;
    logic [LINES-1:0]       irqen_q;
    logic [LINES-1:0]       evten_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            irqen_q <= '0;
            evten_q <= '0;
        end else if (wr_i) begin
            for (int r = 0; r < ROUTE_REGS; r++) begin
                if (addr_i == ADDR_W'(r))
                    route_q[r*ROUTE_BITS +: ROUTE_BITS] <= wdata_i[ROUTE_BITS-1:0];
            end
            if (addr_i == ADDR_W'(ADDR_RISE_EN)) rise_q  <= wdata_i[LINES-1:0];
            if (addr_i == ADDR_W'(ADDR_FALL_EN)) fall_q  <= wdata_i[LINES-1:0];
            if (addr_i == ADDR_W'(ADDR_IRQ_EN))  irqen_q <= wdata_i[LINES-1:0];
            if (addr_i == ADDR_W'(ADDR_EVT_EN))  evten_q <= wdata_i[LINES-1:0];
        end
    end

    // Write-one-to-clear strobes for the pending flags held in each line.
    assign clr_o = (wr_i && addr_i == ADDR_W'(ADDR_PENDING)) ? wdata_i[LINES-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < ROUTE_REGS; r++) begin
            if (addr_i == ADDR_W'(r))
                rdata_o[ROUTE_BITS-1:0] = route_q[r*ROUTE_BITS +: ROUTE_BITS];
        end
        if (addr_i == ADDR_W'(ADDR_RISE_EN)) rdata_o[LINES-1:0] = rise_q;
        if (addr_i == ADDR_W'(ADDR_FALL_EN)) rdata_o[LINES-1:0] = fall_q;
        if (addr_i == ADDR_W'(ADDR_IRQ_EN))  rdata_o[LINES-1:0] = irqen_q;
        if (addr_i == ADDR_W'(ADDR_EVT_EN))  rdata_o[LINES-1:0] = evten_q;
        if (addr_i == ADDR_W'(ADDR_PENDING)) rdata_o[LINES-1:0] = pend_i;
    end

    for (genvar n = 0; n < LINES; n++) begin : g_cfg
        assign cfg_o[n] = '{sel:     route_q[n*SEL_W +: SEL_W],
                            rise_en: rise_q[n],
                            fall_en: fall_q[n],
                            irq_en:  irqen_q[n],
                            evt_en:  evten_q[n]};
    end

    AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ($stable(route_q) && $stable(rise_q) && $stable(fall_q)
                   && $stable(irqen_q) && $stable(evten_q))); // R9

endmodule

// File: rtl/eirq_line.sv
module eirq_line
    import edge_irq_pkg::*;
#(
    parameter int NUM_PORTS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] src_i,
    input  line_cfg_t            cfg_i,
    input  logic                 clr_i,
    output logic                 pend_o,
    output logic                 irq_o,
    output logic                 evt_o
);
    logic             cur;
    logic             prev_q;
    logic [SEL_W-1:0] sel_q;
    logic             pend_q;
    logic             evt_q;
    logic             stable;
    logic             trig;

    // Source mux; selector values with no port behind them read as 0.
    always_comb begin
        cur = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cfg_i.sel == SEL_W'(p)) cur = src_i[p];
        end
    end

    // A selector change reloads the history instead of reporting an edge.
    assign stable = (sel_q == cfg_i.sel);
    assign trig   = edge_hit(prev_q, cur, stable, cfg_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            sel_q  <= '0;
            pend_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= cur;
            sel_q  <= cfg_i.sel;
            evt_q  <= trig & cfg_i.evt_en;
            pend_q <= (pend_q & ~clr_i) | (trig & cfg_i.irq_en);
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & cfg_i.irq_en;
    assign evt_o  = evt_q;

    AST_SEL_CHANGE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.sel != $past(cfg_i.sel)) |=> (!evt_o && !$rose(pend_q))); // R8

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> pend_q); // R7

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (trig && cfg_i.irq_en && clr_i) |=> pend_q); // R7

    AST_PEND_NEEDS_IRQ_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(cfg_i.irq_en)); // R5

    AST_EVT_NEEDS_EVT_EN: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> $past(cfg_i.evt_en)); // R4

endmodule

// File: rtl/edge_irq_router.sv
module edge_irq_router
    import edge_irq_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS*LINES-1:0] pin_in,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [LINES-1:0]           irq_o,
    output logic [LINES-1:0]           evt_o
);
    localparam int PIN_W = NUM_PORTS * LINES;

    logic [PIN_W-1:0]      pin_s;
    line_cfg_t [LINES-1:0] cfg;
    logic [LINES-1:0]      clr;
    logic [LINES-1:0]      pend;

    eirq_pin_sync #(.W(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_in),
        .q_o (pin_s)
    );

    eirq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .pend_i  (pend),
        .cfg_o   (cfg),
        .clr_o   (clr),
        .rdata_o (bus_rdata)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic [NUM_PORTS-1:0] src;
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src
            assign src[p] = pin_s[p*LINES + n];
        end
        eirq_line #(.NUM_PORTS(NUM_PORTS)) u_line (
            .clk    (clk),
            .rst    (rst),
            .src_i  (src),
            .cfg_i  (cfg[n]),
            .clr_i  (clr[n]),
            .pend_o (pend[n]),
            .irq_o  (irq_o[n]),
            .evt_o  (evt_o[n])
        );
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (irq_o == '0 && evt_o == '0)); // R1

endmodule

// File: tb/tb_edge_irq_router.sv
module tb_edge_irq_router;
    localparam int NP = 7;
    localparam int NL = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP*NL-1:0]  pins = '0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NL-1:0]     irq_o;
    logic [NL-1:0]     evt_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    edge_irq_router #(.NUM_PORTS(NP), .ADDR_W(4), .DATA_W(32)) dut (
        .clk (clk), .rst (rst), .pin_in (pins),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq_o (irq_o), .evt_o (evt_o)
    );

    typedef struct packed {
        logic [3:0] line;
        logic [2:0] port;
        logic rise, fall, ien, een, from, to, x_evt, x_pend;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{4'd0,  3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{4'd5,  3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd5,  3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd10, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{4'd15, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'd7,  3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd12, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd3,  3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = 4'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet_all();
        wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit seen;

        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R1: reset state
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 evt", 32'(evt_o), 32'h0);
        for (int a = 0; a < 9; a++) begin
            rd(a, d);
            chk("R1 readback", d, 32'h0);
        end

        // Table walk: R3 triggers, R4 events, R5 pending, R6 request
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            int ln;
            v  = TABLE[i];
            ln = int'(v.line);
            quiet_all();
            pins = '0;
            pins[int'(v.port)*NL + ln] = v.from;
            wait_n(4);
            wr(ln / 4, 32'(v.port) << (4 * (ln % 4)));
            wait_n(2);
            wr(4, 32'(v.rise) << ln);
            wr(5, 32'(v.fall) << ln);
            wr(6, 32'(v.ien) << ln);
            wr(7, 32'(v.een) << ln);
            wr(8, 32'hFFFF);
            pins[int'(v.port)*NL + ln] = v.to;
            wait_n(3);
            chk("R4 event pulse", 32'(evt_o), 32'(v.x_evt) << ln);
            chk("R6 irq", 32'(irq_o), 32'(v.x_pend) << ln);
            rd(8, d);
            chk("R3 R5 pending", d, 32'(v.x_pend) << ln);
            wait_n(1);
            chk("R4 single cycle", 32'(evt_o), 32'h0);
        end

        // R6: masking hides the request but keeps pending
        quiet_all();
        pins = '0;
        wr(1, 32'h0);
        wait_n(4);
        wr(4, 32'h10); wr(6, 32'h10); wr(8, 32'hFFFF);
        pins[4] = 1'b1;
        wait_n(3);
        chk("R6 irq set", 32'(irq_o), 32'h10);
        wr(6, 32'h0);
        chk("R6 masked irq", 32'(irq_o), 32'h0);
        rd(8, d);
        chk("R6 pending kept", d, 32'h10);
        wr(6, 32'h10);
        chk("R6 unmasked irq", 32'(irq_o), 32'h10);

        // R7: write-one-to-clear
        wr(8, 32'h0);
        rd(8, d);
        chk("R7 zero write keeps", d, 32'h10);
        wr(8, 32'h8);
        rd(8, d);
        chk("R7 other bit keeps", d, 32'h10);
        wr(8, 32'h10);
        rd(8, d);
        chk("R7 one clears", d, 32'h0);

        // R7: edge and clear in the same cycle, edge wins
        pins[4] = 1'b0;
        wait_n(4);
        pins[4] = 1'b1;
        wait_n(2);
        wr(8, 32'h10);
        rd(8, d);
        chk("R7 edge wins", d, 32'h10);
        wr(8, 32'h10);
        rd(8, d);
        chk("R7 clear after", d, 32'h0);

        // R8: selector change between differing levels is silent
        quiet_all();
        pins = '0;
        pins[1*NL + 1] = 1'b1;
        wr(0, 32'h0);
        wait_n(4);
        wr(4, 32'h2); wr(5, 32'h2); wr(6, 32'h2); wr(7, 32'h2); wr(8, 32'hFFFF);
        wr(0, 32'h10);
        seen = 1'b0;
        for (int c = 0; c < 6; c++) begin
            if (evt_o[1]) seen = 1'b1;
            wait_n(1);
        end
        chk("R8 no event on reselect", 32'(seen), 32'h0);
        rd(8, d);
        chk("R8 no pending on reselect", d, 32'h0);
        pins[1*NL + 1] = 1'b0;
        wait_n(3);
        chk("R8 new source edge", 32'(evt_o), 32'h2);

        // R2: routing, unselected ports and out-of-range selector
        quiet_all();
        pins = '0;
        wr(0, 32'h300);
        wait_n(4);
        wr(4, 32'h4); wr(6, 32'h4); wr(8, 32'hFFFF);
        pins[0*NL + 2] = 1'b1;
        pins[4*NL + 2] = 1'b1;
        wait_n(4);
        rd(8, d);
        chk("R2 unselected port ignored", d, 32'h0);
        wr(0, 32'h900);
        wait_n(3);
        for (int p = 0; p < NP; p++) pins[p*NL + 2] = 1'b1;
        wait_n(4);
        rd(8, d);
        chk("R2 out of range selector", d, 32'h0);
        wr(0, 32'h300);
        wait_n(4);
        rd(8, d);
        chk("R8 reselect to high source", d, 32'h0);
        pins[3*NL + 2] = 1'b0;
        wait_n(4);
        pins[3*NL + 2] = 1'b1;
        wait_n(4);
        rd(8, d);
        chk("R2 selected port drives", d, 32'h4);

        // R9: readback and unused addresses
        wr(0, 32'hFFFF_A5C3);
        rd(0, d); chk("R9 route0", d, 32'h0000_A5C3);
        wr(3, 32'h1234);
        rd(3, d); chk("R9 route3", d, 32'h1234);
        wr(5, 32'hFFFF_FFFF);
        rd(5, d); chk("R9 fall upper zero", d, 32'h0000_FFFF);
        wr(7, 32'h0F0F);
        rd(7, d); chk("R9 evt enable", d, 32'h0F0F);
        wr(9, 32'hFFFF);
        rd(9, d); chk("R9 unused address", d, 32'h0);
        rd(5, d); chk("R9 unused write no effect", d, 32'h0000_FFFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule